// File: doc/BRIEF.md
# Critical Temperature Alarm Controller

This block watches a local and a remote temperature channel, each compared every clock against its own programmable critical limit. A channel whose reading reaches its limit trips, pulls the shared alarm pin low and latches an over-critical status flag. The tripped channel keeps the alarm asserted until its reading has dropped a hysteresis band of 5 degrees below the limit. Only then does it return to the armed state and become able to trip again.

Status flags are cleared by a status-read strobe. A flag cleared while its channel is still hot stays clear, because a flag is only set on the armed-to-tripped transition. A remote sensor fault strobe sets a sticky fault flag and forces the alarm low. Only the asynchronous reset or the synchronous soft reset removes that fault. An alarm enable selects between a high-impedance pin and an active open-drain stage. An active-low alert request combines every flag with its own interrupt enable.

Each channel is a two-state machine: `CH_ARMED` moves to `CH_TRIPPED` on transition *trip* (reading >= limit). `CH_TRIPPED` returns to `CH_ARMED` on transition *rearm* (reading < limit - 5, with the threshold saturated at -128) or on a soft reset. The fault latch has states `FLT_CLEAR` and `FLT_STUCK`. It takes transition *fault* when the strobe is seen and transition *clear* only on a soft reset. The asynchronous reset puts every machine in its first state.

Top module: `crit_temp_alarm`

## Requirements
- R1: After reset all three flags are 0, alarm_oe and alarm_low are 0 and alert_n is 1.
- R2: A channel whose signed reading is equal to or above its limit trips; on the next clock its flag is 1 and, with alarm_en = 1, alarm_low is 1.
- R3: A reading one below the limit does not trip the channel and sets no flag.
- R4: A tripped channel keeps the alarm while its reading is at limit - 5 or higher and releases it once the reading is below limit - 5; the flag is not cleared by this release.
- R5: A status read clears the two over-critical flags on the next clock; a cleared flag is not set again while the channel stays tripped, and is set again only after a rearm followed by a new trip.
- R6: When a status read and a trip fall in the same cycle, the flag is 1 afterwards.
- R7: A fault strobe sets flag_rtf on the next clock; flag_rtf and the forced-low alarm remain after the strobe ends, whatever rtf_ie is.
- R8: Soft reset clears all three flags and returns both channels to the armed state on the next clock.
- R9: With alarm_en = 0 the pin is high-impedance (alarm_oe = 0, alarm_low = 0) while the flags still update; with alarm_en = 1, alarm_oe = 1 and alarm_low is the OR of both tripped channels and flag_rtf.
- R10: alert_n is 0 exactly when some flag is 1 together with its own interrupt enable (ltc_ie, rtc_ie, rtf_ie).
- R11: The two channels are independent; a trip on the remote channel leaves the local flag at 0.
- R12: For a limit below -123 the rearm threshold saturates at -128, so a tripped channel stays tripped even at reading -128.
- R13: A status read does not clear flag_rtf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of flags and channel states |
| temp_local | input | TW | Signed local reading, whole degrees |
| temp_remote | input | TW | Signed remote reading, whole degrees |
| limit_local | input | TW | Signed local critical limit |
| limit_remote | input | TW | Signed remote critical limit |
| fault_strobe | input | 1 | Remote sensor short/open detected |
| status_rd | input | 1 | Status read strobe, clears over-critical flags |
| alarm_en | input | 1 | Enables the alarm output stage |
| ltc_ie | input | 1 | Interrupt enable for the local over-critical flag |
| rtc_ie | input | 1 | Interrupt enable for the remote over-critical flag |
| rtf_ie | input | 1 | Interrupt enable for the sensor fault flag |
| alarm_oe | output | 1 | Output stage enabled (0 = high impedance) |
| alarm_low | output | 1 | Pin actively pulled low |
| flag_ltc | output | 1 | Local over-critical flag |
| flag_rtc | output | 1 | Remote over-critical flag |
| flag_rtf | output | 1 | Sticky remote sensor fault flag |
| alert_n | output | 1 | Alert request, active low |

## Verification
The hardest situation to reach is a flag that was cleared while its channel is still hot and must stay clear. The stimulus holds the reading above the limit across a status read. It then walks the reading down through limit - 5 and limit - 6 and back up, so that the clear, the hold, the rearm and the new trip are seen in separate cycles. The coincident read-and-trip case needs both strobes on the same edge. The bench drives them at one falling edge so that they share a rising edge. The saturated rearm threshold is reached by programming a limit near the negative end of the range.

// File: rtl/crit_alarm_pkg.sv
package crit_alarm_pkg;
    typedef enum logic {CH_ARMED, CH_TRIPPED} ch_state_t;
    typedef enum logic {FLT_CLEAR, FLT_STUCK} flt_state_t;
endpackage

// File: rtl/crit_chan_fsm.sv
module crit_chan_fsm
    import crit_alarm_pkg::*;
#(
    parameter int TW   = 8,
    parameter int HYST = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic signed [TW-1:0] temp,
    input  logic signed [TW-1:0] limit,
    input  logic                 status_rd,
    output logic                 alarm,
    output logic                 flag
);
    localparam int MINV = -(2 ** (TW - 1));
    localparam logic signed [TW:0] MIN_EXT = MINV;
    localparam logic signed [TW:0] HYST_EXT = HYST;

    ch_state_t state, nxt;
    logic signed [TW:0]   rearm_ext;
    logic signed [TW-1:0] rearm;
    logic hot, cool, trip_evt;

    // rearm threshold = limit - HYST, saturated at the most negative value
    always_comb begin
        rearm_ext = {limit[TW-1], limit} - HYST_EXT;
        rearm     = (rearm_ext < MIN_EXT) ? MIN_EXT[TW-1:0] : rearm_ext[TW-1:0];
        hot       = (temp >= limit);
        cool      = (temp < rearm);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CH_ARMED:   if (hot)  nxt = CH_TRIPPED;
            CH_TRIPPED: if (cool) nxt = CH_ARMED;
            default:    nxt = CH_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= CH_ARMED;
        else if (soft_rst) state <= CH_ARMED;
        else               state <= nxt;
    end

    // flag: clear by read first, then a new trip sets it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (soft_rst) flag <= 1'b0;
        else               flag <= (flag & ~status_rd) | trip_evt;
    end

    always_comb begin
        trip_evt = (state == CH_ARMED) && hot;
        alarm    = (state == CH_TRIPPED);
    end
endmodule

// File: rtl/crit_fault_latch.sv
module crit_fault_latch
    import crit_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic fault_strobe,
    output logic stuck
);
    flt_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            FLT_CLEAR: if (fault_strobe) nxt = FLT_STUCK;
            FLT_STUCK: nxt = FLT_STUCK;
            default:   nxt = FLT_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= FLT_CLEAR;
        else if (soft_rst) state <= FLT_CLEAR;
        else               state <= nxt;
    end

    always_comb stuck = (state == FLT_STUCK);
endmodule

// File: rtl/crit_temp_alarm.sv
module crit_temp_alarm #(
    parameter int TW   = 8,
    parameter int HYST = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic signed [TW-1:0] temp_local,
    input  logic signed [TW-1:0] temp_remote,
    input  logic signed [TW-1:0] limit_local,
    input  logic signed [TW-1:0] limit_remote,
    input  logic                 fault_strobe,
    input  logic                 status_rd,
    input  logic                 alarm_en,
    input  logic                 ltc_ie,
    input  logic                 rtc_ie,
    input  logic                 rtf_ie,
    output logic                 alarm_oe,
    output logic                 alarm_low,
    output logic                 flag_ltc,
    output logic                 flag_rtc,
    output logic                 flag_rtf,
    output logic                 alert_n
);
    localparam int NUM_CH    = 2;
    localparam int CH_LOCAL  = 0;
    localparam int CH_REMOTE = 1;

    logic signed [TW-1:0] temp_arr  [NUM_CH];
    logic signed [TW-1:0] limit_arr [NUM_CH];
    logic [NUM_CH-1:0] ch_alarm, ch_flag, ch_ie;

    assign temp_arr[CH_LOCAL]   = temp_local;
    assign temp_arr[CH_REMOTE]  = temp_remote;
    assign limit_arr[CH_LOCAL]  = limit_local;
    assign limit_arr[CH_REMOTE] = limit_remote;
    assign ch_ie                = {rtc_ie, ltc_ie};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        crit_chan_fsm #(.TW(TW), .HYST(HYST)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (soft_rst),
            .temp      (temp_arr[c]),
            .limit     (limit_arr[c]),
            .status_rd (status_rd),
            .alarm     (ch_alarm[c]),
            .flag      (ch_flag[c])
        );
    end

    crit_fault_latch u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .fault_strobe (fault_strobe),
        .stuck        (flag_rtf)
    );

    always_comb begin
        flag_ltc  = ch_flag[CH_LOCAL];
        flag_rtc  = ch_flag[CH_REMOTE];
        alarm_oe  = alarm_en;
        alarm_low = alarm_en & ((|ch_alarm) | flag_rtf);
        alert_n   = ~((|(ch_flag & ch_ie)) | (flag_rtf & rtf_ie));
    end
endmodule

// File: rtl/crit_temp_alarm_chk.sv
module crit_temp_alarm_chk #(
    parameter int TW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_rst,
    input logic signed [TW-1:0] temp_local,
    input logic signed [TW-1:0] limit_local,
    input logic                 status_rd,
    input logic                 alarm_en,
    input logic                 alarm_oe,
    input logic                 alarm_low,
    input logic                 flag_ltc,
    input logic                 flag_rtc,
    input logic                 flag_rtf,
    input logic                 alert_n
);
    p_hiz_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_oe |-> !alarm_low);

    p_trip_pulls_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && !soft_rst && (temp_local >= limit_local)) |=> (alarm_low || !alarm_en));

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rtf && !soft_rst) |=> flag_rtf);

    p_fault_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rtf && alarm_en) |-> alarm_low);

    p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!flag_ltc && !flag_rtc && !flag_rtf));

    p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ltc && !status_rd && !soft_rst) |=> flag_ltc);

    p_no_flag_no_alert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_ltc && !flag_rtc && !flag_rtf) |-> alert_n);
endmodule

bind crit_temp_alarm crit_temp_alarm_chk #(.TW(TW)) u_chk (.*);

// File: tb/test_crit_temp_alarm.sv
`timescale 1ns/1ps
module test_crit_temp_alarm;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic signed [7:0] temp_local = '0, temp_remote = '0;
    logic signed [7:0] limit_local = 8'sd50, limit_remote = 8'sd80;
    logic fault_strobe = 1'b0, status_rd = 1'b0, alarm_en = 1'b0;
    logic ltc_ie = 1'b0, rtc_ie = 1'b0, rtf_ie = 1'b0;
    logic alarm_oe, alarm_low, flag_ltc, flag_rtc, flag_rtf, alert_n;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    crit_temp_alarm i_crit_temp_alarm (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic read_pulse();
        status_rd = 1'b1; step(); status_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "flag_ltc", flag_ltc, 1'b0);
        chk("R1", "flag_rtc", flag_rtc, 1'b0);
        chk("R1", "flag_rtf", flag_rtf, 1'b0);
        chk("R1", "alarm_oe", alarm_oe, 1'b0);
        chk("R1", "alarm_low", alarm_low, 1'b0);
        chk("R1", "alert_n", alert_n, 1'b1);
    endtask

    task automatic t_trip_and_hyst();
        alarm_en = 1'b1; temp_local = 8'sd49; step();
        chk("R3", "no trip below", alarm_low, 1'b0);
        chk("R3", "no flag below", flag_ltc, 1'b0);
        chk("R9", "oe when enabled", alarm_oe, 1'b1);
        temp_local = 8'sd50; step();
        chk("R2", "trip at equal", alarm_low, 1'b1);
        chk("R2", "flag at equal", flag_ltc, 1'b1);
        chk("R11", "remote untouched", flag_rtc, 1'b0);
        temp_local = 8'sd45; step();
        chk("R4", "held at limit-5", alarm_low, 1'b1);
        temp_local = 8'sd44; step();
        chk("R4", "released below limit-5", alarm_low, 1'b0);
        chk("R4", "flag kept after release", flag_ltc, 1'b1);
        read_pulse();
        chk("R5", "read clears", flag_ltc, 1'b0);
    endtask

    task automatic t_read_while_hot();
        temp_local = 8'sd60; step();
        chk("R5", "trip flag", flag_ltc, 1'b1);
        read_pulse();
        chk("R5", "cleared while hot", flag_ltc, 1'b0);
        step(); step();
        chk("R5", "no reassert while hot", flag_ltc, 1'b0);
        chk("R5", "alarm still low", alarm_low, 1'b1);
        temp_local = 8'sd40; step();
        chk("R5", "rearmed", alarm_low, 1'b0);
        chk("R5", "flag still clear", flag_ltc, 1'b0);
        temp_local = 8'sd60; step();
        chk("R5", "reassert after rearm", flag_ltc, 1'b1);
        temp_local = 8'sd0; step(); read_pulse();
    endtask

    task automatic t_coincide();
        temp_local = 8'sd55; status_rd = 1'b1; step(); status_rd = 1'b0;
        chk("R6", "trip wins over read", flag_ltc, 1'b1);
        temp_local = 8'sd0; step(); read_pulse();
        chk("R6", "cleanup", flag_ltc, 1'b0);
    endtask

    task automatic t_remote();
        temp_remote = 8'sd90; step();
        chk("R11", "remote flag", flag_rtc, 1'b1);
        chk("R11", "local flag clear", flag_ltc, 1'b0);
        chk("R11", "remote alarm", alarm_low, 1'b1);
        temp_remote = 8'sd0; step(); read_pulse();
    endtask

    task automatic t_enable_alert();
        alarm_en = 1'b0; temp_local = 8'sd60; step();
        chk("R9", "hiz oe", alarm_oe, 1'b0);
        chk("R9", "hiz low", alarm_low, 1'b0);
        chk("R9", "flag updates", flag_ltc, 1'b1);
        chk("R10", "flag without ie", alert_n, 1'b1);
        rtc_ie = 1'b1; step();
        chk("R10", "other ie only", alert_n, 1'b1);
        ltc_ie = 1'b1; step();
        chk("R10", "flag with ie", alert_n, 1'b0);
        alarm_en = 1'b1; step();
        chk("R9", "enabled drives", alarm_low, 1'b1);
        temp_local = 8'sd0; step(); read_pulse();
        chk("R10", "alert released", alert_n, 1'b1);
        ltc_ie = 1'b0; rtc_ie = 1'b0;
    endtask

    task automatic t_fault_soft();
        fault_strobe = 1'b1; step(); fault_strobe = 1'b0;
        chk("R7", "rtf set", flag_rtf, 1'b1);
        chk("R7", "forced low", alarm_low, 1'b1);
        chk("R7", "no alert with ie 0", alert_n, 1'b1);
        step(); step();
        chk("R7", "sticky", flag_rtf, 1'b1);
        chk("R7", "still forced", alarm_low, 1'b1);
        read_pulse();
        chk("R13", "read keeps rtf", flag_rtf, 1'b1);
        rtf_ie = 1'b1; step();
        chk("R10", "rtf alert", alert_n, 1'b0);
        temp_local = 8'sd70; step();
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
        chk("R8", "rtf cleared", flag_rtf, 1'b0);
        chk("R8", "ltc cleared", flag_ltc, 1'b0);
        chk("R8", "channel armed", alarm_low, 1'b0);
        temp_local = 8'sd0; rtf_ie = 1'b0; step(); read_pulse();
    endtask

    task automatic t_saturate();
        limit_local = -8'sd125; temp_local = -8'sd125; step();
        chk("R12", "trip near minimum", alarm_low, 1'b1);
        temp_local = -8'sd128; step(); step();
        chk("R12", "no rearm at -128", alarm_low, 1'b1);
        limit_local = 8'sd127; step();
        chk("R12", "rearm with high limit", alarm_low, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_trip_and_hyst();
        t_read_while_hot();
        t_coincide();
        t_remote();
        t_enable_alert();
        t_fault_soft();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule